// File: doc/BRIEF.md
# Multicycle Instruction Sequencer

This block is a small processor core that carries one instruction at a time through a control state machine over a single shared datapath. Every instruction first goes through a fetch state and an operand-read state. It then follows a short path of states that belongs to its class: register-register arithmetic, register-immediate arithmetic, load, store, conditional branch or jump. The datapath holds an instruction register, two operand latches (A and B), a result latch, a writeback latch and a 32-entry register file.

Instruction and data memory are internal word arrays that are filled before reset is released. The core runs until it meets an encoding it does not recognise. At that point it raises a sticky halt flag and stops. The final contents of the register file can then be read one register at a time through a registered debug read port.

Top module: `mcs_core`

## Requirements
- R1: While reset is high and in the cycle after it is released, halt is low and the program counter is 0. Reset also clears the debug output to 0.
- R2: The fetch state loads the instruction register from instruction memory word PC[9:2] and adds 4 to PC. The next state latches A from the register named by instruction bits 25:21 and B from the register named by bits 20:16.
- R3: Opcode 0x00 is a register-register operation. The destination is bits 15:11 and the function is bits 10:0: 0 add, 1 subtract (A-B), 2 and, 3 or, 4 xor, 5 signed set-less-than, 6 shift left by B[4:0], 7 logical shift right by B[4:0].
- R4: Register-immediate operations write the register named by bits 20:16, using the sign-extended 16-bit field 15:0 in place of B: 0x08 add, 0x0A signed set-less-than, 0x0C and, 0x0D or, 0x0E xor.
- R5: Opcode 0x23 loads the register named by bits 20:16 with the data memory word at (A + sign-extended immediate). Address bits 9:2 select the word; the low two bits are ignored and higher bits wrap.
- R6: Opcode 0x2B writes B to data memory at (A + sign-extended immediate), using the same word selection as loads, and changes no register.
- R7: Opcode 0x04 branches when A equals B and opcode 0x05 branches when they differ. A taken branch sets PC to the already-incremented PC plus the sign-extended immediate shifted left by 2. An untaken branch continues in sequence.
- R8: Opcode 0x02 sets PC to the 26-bit field 25:0 shifted left by 2, zero-extended.
- R9: Register 0 always reads as zero, and writes to it are discarded.
- R10: Any other opcode, or opcode 0x00 with a function value above 7, sets halt. Once set, halt stays high and no register or memory is written until reset.
- R11: The debug output shows the register selected by the debug address one clock edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dbg_sel | input | 5 | Register number for the debug read |
| halt | output | 1 | High once an unrecognised encoding has been decoded |
| dbg_data | output | 32 | Registered contents of the selected register |

## Verification
The situations that are hardest to reach from the ports are the control-flow paths that get no visible result of their own. These are a taken branch or a jump that must skip an instruction, a store whose only trace is a later load, and a wrapped load address built from an arbitrary base register. The stimulus reaches them with seeded random programs and directed programs. Each program starts by writing every register with a known value. Forward-only branches and jumps then place detectable writes in the skipped slots, and loads and stores use random base registers and displacements, so the addresses wrap. A bench-side instruction interpreter predicts the whole register file, and the bench compares all 31 registers through the debug port after halt.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

  localparam logic [5:0] OP_RR   = 6'h00;
  localparam logic [5:0] OP_JMP  = 6'h02;
  localparam logic [5:0] OP_BEQ  = 6'h04;
  localparam logic [5:0] OP_BNE  = 6'h05;
  localparam logic [5:0] OP_ADDI = 6'h08;
  localparam logic [5:0] OP_SLTI = 6'h0A;
  localparam logic [5:0] OP_ANDI = 6'h0C;
  localparam logic [5:0] OP_ORI  = 6'h0D;
  localparam logic [5:0] OP_XORI = 6'h0E;
  localparam logic [5:0] OP_LW   = 6'h23;
  localparam logic [5:0] OP_SW   = 6'h2B;

  localparam int unsigned NUM_FUNCT = 8;

  typedef enum logic [2:0] {
    ALU_ADD = 3'd0,
    ALU_SUB = 3'd1,
    ALU_AND = 3'd2,
    ALU_OR  = 3'd3,
    ALU_XOR = 3'd4,
    ALU_SLT = 3'd5,
    ALU_SLL = 3'd6,
    ALU_SRL = 3'd7
  } alu_op_e;

  typedef enum logic [2:0] {
    C_RR, C_RI, C_LD, C_ST, C_BR, C_JMP, C_BAD
  } iclass_e;

  typedef enum logic [3:0] {
    S_FETCH, S_DECODE, S_EX_RR, S_EX_RI, S_ADDR, S_LD_RD, S_LD_CAP,
    S_ST_WR, S_BRANCH, S_JUMP, S_ALU_WB, S_REG_WR, S_HALT
  } state_e;

  typedef struct packed {
    iclass_e     iclass;
    alu_op_e     alu_op;
    logic [4:0]  rd;
    logic [31:0] imm;
    logic        br_ne;
    logic [25:0] target;
  } dec_t;

endpackage

// File: rtl/mcs_decode.sv
module mcs_decode
  import mcs_pkg::*;
(
  input  logic [31:0] ir,
  output dec_t        dec
);

  logic [5:0]  opcode;
  logic [10:0] funct;

  assign opcode = ir[31:26];
  assign funct  = ir[10:0];

  always_comb begin
    dec        = '0;
    dec.iclass = C_BAD;
    dec.alu_op = ALU_ADD;
    dec.rd     = ir[20:16];
    dec.imm    = {{16{ir[15]}}, ir[15:0]};
    dec.target = ir[25:0];
    dec.br_ne  = 1'b0;
    case (opcode)
      OP_RR: begin
        dec.rd = ir[15:11];
        if (funct < 11'(NUM_FUNCT)) begin
          dec.iclass = C_RR;
          dec.alu_op = alu_op_e'(funct[2:0]);
        end
      end
      OP_ADDI: begin dec.iclass = C_RI; dec.alu_op = ALU_ADD; end
      OP_SLTI: begin dec.iclass = C_RI; dec.alu_op = ALU_SLT; end
      OP_ANDI: begin dec.iclass = C_RI; dec.alu_op = ALU_AND; end
      OP_ORI:  begin dec.iclass = C_RI; dec.alu_op = ALU_OR;  end
      OP_XORI: begin dec.iclass = C_RI; dec.alu_op = ALU_XOR; end
      OP_LW:   dec.iclass = C_LD;
      OP_SW:   dec.iclass = C_ST;
      OP_BEQ:  dec.iclass = C_BR;
      OP_BNE:  begin dec.iclass = C_BR; dec.br_ne = 1'b1; end
      OP_JMP:  dec.iclass = C_JMP;
      default: dec.iclass = C_BAD;
    endcase
  end

endmodule

// File: rtl/mcs_alu.sv
module mcs_alu
  import mcs_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  alu_op_e           op,
  input  logic [XLEN-1:0]   a,
  input  logic [XLEN-1:0]   b,
  output logic [XLEN-1:0]   y
);

  localparam int SHW = $clog2(XLEN);

  logic lt;
  assign lt = $signed(a) < $signed(b);

  always_comb begin
    case (op)
      ALU_ADD: y = a + b;
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_XOR: y = a ^ b;
      ALU_SLT: y = {{(XLEN-1){1'b0}}, lt};
      ALU_SLL: y = a << b[SHW-1:0];
      ALU_SRL: y = a >> b[SHW-1:0];
      default: y = a + b;
    endcase
  end

endmodule

// File: rtl/mcs_regfile.sv
module mcs_regfile #(
  parameter int XLEN = 32,
  parameter int NREG = 32,
  parameter int NRD  = 3
) (
  input  logic                            clk,
  input  logic                            we,
  input  logic [$clog2(NREG)-1:0]         waddr,
  input  logic [XLEN-1:0]                 wdata,
  input  logic [NRD-1:0][$clog2(NREG)-1:0] raddr,
  output logic [NRD-1:0][XLEN-1:0]        rdata
);

  localparam int RAW = $clog2(NREG);

  logic [XLEN-1:0] regs [NREG];

  always_ff @(posedge clk) begin
    if (we && (waddr != '0)) regs[waddr] <= wdata;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata[g] = (raddr[g] == RAW'(0)) ? '0 : regs[raddr[g]];
  end

endmodule

// File: rtl/mcs_ram.sv
module mcs_ram #(
  parameter int DEPTH = 256,
  parameter int DW    = 32
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [DW-1:0]            wdata,
  input  logic                     re,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [DW-1:0]            rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end

endmodule

// File: rtl/mcs_core.sv
module mcs_core
  import mcs_pkg::*;
#(
  parameter int XLEN       = 32,
  parameter int NREG       = 32,
  parameter int IMEM_WORDS = 256,
  parameter int DMEM_WORDS = 256
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [$clog2(NREG)-1:0] dbg_sel,
  output logic                    halt,
  output logic [XLEN-1:0]         dbg_data
);

  localparam int RAW = $clog2(NREG);
  localparam int IAW = $clog2(IMEM_WORDS);
  localparam int DAW = $clog2(DMEM_WORDS);
  localparam int NRD = 3;

  state_e          state_q;
  logic [XLEN-1:0] pc_q, a_q, b_q, res_q, wb_q;
  logic            halt_q;
  logic [XLEN-1:0] dbg_q;

  logic [31:0]     ir;
  dec_t            dec;
  logic [XLEN-1:0] dmem_q;

  logic            imem_re, dmem_re, dmem_we, rf_we;
  logic [NRD-1:0][RAW-1:0]  rf_raddr;
  logic [NRD-1:0][XLEN-1:0] rf_rdata;

  alu_op_e         alu_op;
  logic [XLEN-1:0] alu_b, alu_y;
  logic            br_take;

  // strobes follow the state alone
  assign imem_re = (state_q == S_FETCH);
  assign dmem_re = (state_q == S_LD_RD);
  assign dmem_we = (state_q == S_ST_WR);
  assign rf_we   = (state_q == S_REG_WR);

  mcs_ram #(.DEPTH(IMEM_WORDS), .DW(32)) u_imem (
    .clk   (clk),
    .we    (1'b0),
    .waddr ('0),
    .wdata ('0),
    .re    (imem_re),
    .raddr (pc_q[IAW+1:2]),
    .rdata (ir)
  );

  mcs_ram #(.DEPTH(DMEM_WORDS), .DW(XLEN)) u_dmem (
    .clk   (clk),
    .we    (dmem_we),
    .waddr (res_q[DAW+1:2]),
    .wdata (b_q),
    .re    (dmem_re),
    .raddr (res_q[DAW+1:2]),
    .rdata (dmem_q)
  );

  mcs_decode u_dec (
    .ir  (ir),
    .dec (dec)
  );

  assign rf_raddr = {dbg_sel, ir[20:16], ir[25:21]};

  mcs_regfile #(.XLEN(XLEN), .NREG(NREG), .NRD(NRD)) u_rf (
    .clk   (clk),
    .we    (rf_we),
    .waddr (dec.rd),
    .wdata (wb_q),
    .raddr (rf_raddr),
    .rdata (rf_rdata)
  );

  // one ALU serves execute and address states
  always_comb begin
    alu_op = ALU_ADD;
    alu_b  = dec.imm;
    if (state_q == S_EX_RR) begin
      alu_op = dec.alu_op;
      alu_b  = b_q;
    end else if (state_q == S_EX_RI) begin
      alu_op = dec.alu_op;
    end
  end

  mcs_alu #(.XLEN(XLEN)) u_alu (
    .op (alu_op),
    .a  (a_q),
    .b  (alu_b),
    .y  (alu_y)
  );

  assign br_take = (a_q == b_q) ^ dec.br_ne;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_FETCH;
      pc_q    <= '0;
      a_q     <= '0;
      b_q     <= '0;
      res_q   <= '0;
      wb_q    <= '0;
      halt_q  <= 1'b0;
      dbg_q   <= '0;
    end else begin
      dbg_q <= rf_rdata[2];
      case (state_q)
        S_FETCH: begin
          pc_q    <= pc_q + XLEN'(4);
          state_q <= S_DECODE;
        end
        S_DECODE: begin
          a_q <= rf_rdata[0];
          b_q <= rf_rdata[1];
          case (dec.iclass)
            C_RR:    state_q <= S_EX_RR;
            C_RI:    state_q <= S_EX_RI;
            C_LD,
            C_ST:    state_q <= S_ADDR;
            C_BR:    state_q <= S_BRANCH;
            C_JMP:   state_q <= S_JUMP;
            default: begin
              state_q <= S_HALT;
              halt_q  <= 1'b1;
            end
          endcase
        end
        S_EX_RR, S_EX_RI: begin
          res_q   <= alu_y;
          state_q <= S_ALU_WB;
        end
        S_ADDR: begin
          res_q   <= alu_y;
          state_q <= (dec.iclass == C_LD) ? S_LD_RD : S_ST_WR;
        end
        S_LD_RD:  state_q <= S_LD_CAP;
        S_LD_CAP: begin
          wb_q    <= dmem_q;
          state_q <= S_REG_WR;
        end
        S_ST_WR:  state_q <= S_FETCH;
        S_BRANCH: begin
          if (br_take) pc_q <= pc_q + (dec.imm << 2);
          state_q <= S_FETCH;
        end
        S_JUMP: begin
          pc_q    <= XLEN'({dec.target, 2'b00});
          state_q <= S_FETCH;
        end
        S_ALU_WB: begin
          wb_q    <= res_q;
          state_q <= S_REG_WR;
        end
        S_REG_WR: state_q <= S_FETCH;
        S_HALT:   state_q <= S_HALT;
        default:  state_q <= S_HALT;
      endcase
    end
  end

  assign halt     = halt_q;
  assign dbg_data = dbg_q;

endmodule

// File: rtl/mcs_checker.sv
module mcs_checker
  import mcs_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int RAW  = 5
) (
  input logic            clk,
  input logic            rst,
  input state_e          state,
  input logic [XLEN-1:0] pc,
  input logic            halt,
  input logic            rf_we,
  input logic            dmem_we,
  input logic [RAW-1:0]  dbg_sel,
  input logic [XLEN-1:0] dbg_data
);

  assert_reset_clean_R1: assert property (@(posedge clk)
    $past(rst) |-> (pc == '0 && !halt));

  assert_fetch_to_decode_R2: assert property (@(posedge clk) disable iff (rst)
    (state == S_FETCH) |=> (state == S_DECODE));

  assert_pc_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (state != S_FETCH && state != S_BRANCH && state != S_JUMP) |=> $stable(pc));

  assert_mem_path_R5: assert property (@(posedge clk) disable iff (rst)
    (state == S_ADDR) |=> (state == S_LD_RD || state == S_ST_WR));

  assert_pc_aligned_R8: assert property (@(posedge clk) disable iff (rst)
    pc[1:0] == 2'b00);

  assert_zero_reg_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(dbg_sel) == '0) |-> (dbg_data == '0));

  assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    halt |=> (halt && $stable(pc)));

  assert_halt_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    halt |-> (!rf_we && !dmem_we));

endmodule

bind mcs_core mcs_checker #(.XLEN(XLEN), .RAW(RAW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .state    (state_q),
  .pc       (pc_q),
  .halt     (halt),
  .rf_we    (rf_we),
  .dmem_we  (dmem_we),
  .dbg_sel  (dbg_sel),
  .dbg_data (dbg_data)
);

// File: tb/tb_mcs_core.sv
module tb_mcs_core;

  localparam int IW  = 256;
  localparam int DW  = 256;
  localparam logic [31:0] HALT_WORD = 32'hFC00_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  dbg_sel = '0;
  logic        halt;
  logic [31:0] dbg_data;

  int n_chk = 0;
  int n_bad = 0;
  longint cycles = 0;

  logic [31:0] prog  [IW];
  logic [31:0] dinit [DW];
  logic [31:0] mreg  [32];
  logic [31:0] mmem  [DW];
  string       tag   [32];

  always #5 clk = ~clk;

  mcs_core dut (
    .clk      (clk),
    .rst      (rst),
    .dbg_sel  (dbg_sel),
    .halt     (halt),
    .dbg_data (dbg_data)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog R10: actual %0d cycles expected completion", cycles);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  task automatic chk(string tg, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tg, what, act, exp);
    end
  endtask

  function automatic logic [31:0] enc_rr(logic [10:0] f, logic [4:0] rd, logic [4:0] rs, logic [4:0] rt);
    return {6'h00, rs, rt, rd, f};
  endfunction

  function automatic logic [31:0] enc_ri(logic [5:0] op, logic [4:0] rt, logic [4:0] rs, logic [15:0] imm);
    return {op, rs, rt, imm};
  endfunction

  function automatic logic [31:0] enc_j(logic [25:0] tgt);
    return {6'h02, tgt};
  endfunction

  function automatic logic [31:0] alu_m(logic [2:0] f, logic [31:0] a, logic [31:0] b);
    case (f)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return a ^ b;
      3'd5: return {31'b0, $signed(a) < $signed(b)};
      3'd6: return a << b[4:0];
      default: return a >> b[4:0];
    endcase
  endfunction

  // independent instruction-level model of the programme
  task automatic run_model();
    logic [31:0] pc, ir, a, b, imm;
    logic [5:0]  op;
    bit stop;
    int steps;
    pc = 0; stop = 0; steps = 0;
    for (int i = 0; i < 32; i++) mreg[i] = 0;
    for (int i = 0; i < DW; i++) mmem[i] = dinit[i];
    while (!stop && steps < 5000) begin
      ir = prog[pc[9:2]];
      pc = pc + 4;
      steps++;
      op  = ir[31:26];
      a   = mreg[ir[25:21]];
      b   = mreg[ir[20:16]];
      imm = {{16{ir[15]}}, ir[15:0]};
      case (op)
        6'h00: begin
          if (ir[10:0] > 11'd7) stop = 1;
          else if (ir[15:11] != 0) mreg[ir[15:11]] = alu_m(ir[2:0], a, b);
        end
        6'h08: if (ir[20:16] != 0) mreg[ir[20:16]] = a + imm;
        6'h0A: if (ir[20:16] != 0) mreg[ir[20:16]] = alu_m(3'd5, a, imm);
        6'h0C: if (ir[20:16] != 0) mreg[ir[20:16]] = a & imm;
        6'h0D: if (ir[20:16] != 0) mreg[ir[20:16]] = a | imm;
        6'h0E: if (ir[20:16] != 0) mreg[ir[20:16]] = a ^ imm;
        6'h23: begin
          logic [31:0] ad;
          ad = a + imm;
          if (ir[20:16] != 0) mreg[ir[20:16]] = mmem[ad[9:2]];
        end
        6'h2B: begin
          logic [31:0] ad;
          ad = a + imm;
          mmem[ad[9:2]] = b;
        end
        6'h04: if (a == b) pc = pc + (imm << 2);
        6'h05: if (a != b) pc = pc + (imm << 2);
        6'h02: pc = {4'b0, ir[25:0], 2'b00};
        default: stop = 1;
      endcase
    end
  endtask

  task automatic clear_prog();
    for (int i = 0; i < IW; i++) prog[i] = HALT_WORD;
    for (int i = 0; i < DW; i++) dinit[i] = $urandom;
    for (int i = 0; i < 32; i++) tag[i] = "R2";
  endtask

  task automatic read_reg(input logic [4:0] r, output logic [31:0] v);
    @(negedge clk);
    dbg_sel = r;
    @(negedge clk);
    v = dbg_data;
  endtask

  task automatic run_dut(bit first);
    int cyc;
    logic [31:0] v;
    @(negedge clk);
    rst = 1'b1;
    dbg_sel = '0;
    for (int i = 0; i < IW; i++) dut.u_imem.mem[i] = prog[i];
    for (int i = 0; i < DW; i++) dut.u_dmem.mem[i] = dinit[i];
    repeat (3) @(negedge clk);
    if (first) begin
      chk("R1", "halt in reset", {31'b0, halt}, 32'd0);
      chk("R1", "debug output in reset", dbg_data, 32'd0);
    end
    rst = 1'b0;
    @(negedge clk);
    if (first) chk("R1", "halt after release", {31'b0, halt}, 32'd0);
    cyc = 0;
    while (!halt && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    chk("R10", "halt reached", {31'b0, halt}, 32'd1);
    run_model();
    read_reg(5'd0, v);
    chk("R9", "r0 reads zero", v, 32'd0);
    for (int r = 1; r < 32; r++) begin
      read_reg(5'(r), v);
      chk(tag[r], $sformatf("register r%0d", r), v, mreg[r]);
    end
  endtask

  task automatic build_directed();
    int k;
    clear_prog();
    k = 0;
    for (int r = 1; r < 32; r++) prog[k++] = enc_ri(6'h08, 5'(r), 5'd0, 16'(r * 937 - 9000));
    prog[k++] = enc_ri(6'h08, 5'd2, 5'd0, 16'd13);
    for (int f = 0; f < 8; f++) begin
      prog[k++] = enc_rr(11'(f), 5'(10 + f), 5'd1, 5'd2);
      tag[10 + f] = "R3";
    end
    prog[k++] = enc_ri(6'h08, 5'd18, 5'd3, 16'hFFFB);
    prog[k++] = enc_ri(6'h0C, 5'd19, 5'd4, 16'h8F0F);
    prog[k++] = enc_ri(6'h0D, 5'd20, 5'd4, 16'h00F0);
    prog[k++] = enc_ri(6'h0E, 5'd21, 5'd5, 16'hFFFF);
    prog[k++] = enc_ri(6'h0A, 5'd22, 5'd1, 16'h0001);
    for (int r = 18; r < 23; r++) tag[r] = "R4";
    prog[k++] = enc_rr(11'd0, 5'd0, 5'd1, 5'd2);
    prog[k++] = enc_ri(6'h08, 5'd0, 5'd0, 16'd55);
    prog[k++] = enc_rr(11'd0, 5'd23, 5'd0, 5'd0);
    tag[23] = "R9";
    prog[k++] = enc_ri(6'h2B, 5'd5, 5'd0, 16'd8);
    prog[k++] = enc_ri(6'h23, 5'd24, 5'd0, 16'd8);
    tag[24] = "R6";
    prog[k++] = enc_ri(6'h08, 5'd26, 5'd0, 16'd16);
    prog[k++] = enc_ri(6'h23, 5'd25, 5'd26, 16'hFFFC);
    prog[k++] = enc_ri(6'h23, 5'd7, 5'd26, 16'h0402);
    tag[25] = "R5"; tag[7] = "R5";
    prog[k++] = enc_ri(6'h04, 5'd1, 5'd1, 16'd1);
    prog[k++] = enc_ri(6'h08, 5'd27, 5'd0, 16'd1);
    prog[k++] = enc_ri(6'h05, 5'd1, 5'd1, 16'd1);
    prog[k++] = enc_ri(6'h08, 5'd28, 5'd0, 16'd7);
    prog[k++] = enc_ri(6'h05, 5'd2, 5'd1, 16'd1);
    prog[k++] = enc_ri(6'h08, 5'd9, 5'd0, 16'd3);
    prog[k++] = enc_ri(6'h04, 5'd2, 5'd1, 16'd1);
    prog[k++] = enc_ri(6'h08, 5'd6, 5'd0, 16'd4);
    tag[27] = "R7"; tag[28] = "R7"; tag[9] = "R7"; tag[6] = "R7";
    prog[k] = enc_j(26'(k + 2)); k++;
    prog[k++] = enc_ri(6'h08, 5'd29, 5'd0, 16'd1);
    prog[k++] = enc_ri(6'h08, 5'd8, 5'd0, 16'd99);
    tag[29] = "R8"; tag[8] = "R8";
    prog[k++] = enc_rr(11'd8, 5'd30, 5'd1, 5'd2);
    prog[k++] = enc_ri(6'h08, 5'd30, 5'd0, 16'd5);
    prog[k++] = enc_ri(6'h2B, 5'd3, 5'd0, 16'd0);
    tag[30] = "R10";
  endtask

  task automatic build_random();
    int k, n, sel;
    clear_prog();
    k = 0;
    for (int r = 1; r < 32; r++) prog[k++] = enc_ri(6'h08, 5'(r), 5'd0, 16'($urandom));
    n = 60 + int'($urandom % 40);
    for (int i = 0; i < n; i++) begin
      sel = int'($urandom % 20);
      if (sel < 8)
        prog[k] = enc_rr(11'($urandom % 8), 5'($urandom), 5'($urandom), 5'($urandom));
      else if (sel < 13) begin
        logic [5:0] ops [5];
        ops = '{6'h08, 6'h0A, 6'h0C, 6'h0D, 6'h0E};
        prog[k] = enc_ri(ops[$urandom % 5], 5'($urandom), 5'($urandom), 16'($urandom));
      end else if (sel < 15)
        prog[k] = enc_ri(6'h23, 5'($urandom), 5'($urandom), 16'($urandom));
      else if (sel < 17)
        prog[k] = enc_ri(6'h2B, 5'($urandom), 5'($urandom), 16'($urandom));
      else if (sel < 19)
        prog[k] = enc_ri(($urandom % 2) ? 6'h05 : 6'h04, 5'($urandom % 4), 5'($urandom % 4),
                         16'($urandom % 4));
      else
        prog[k] = enc_j(26'(k + 1 + int'($urandom % 3)));
      k++;
    end
  endtask

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20417));
    build_directed();
    run_dut(1'b1);
    repeat (30) @(negedge clk);
    chk("R10", "halt held after idle", {31'b0, halt}, 32'd1);
    read_reg(5'd30, v);
    chk("R10", "r30 untouched after halt", v, mreg[30]);
    read_reg(5'd3, v);
    chk("R11", "debug select r3", v, mreg[3]);
    for (int t = 0; t < 14; t++) begin
      build_random();
      run_dut(1'b0);
    end
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule